// File: doc/BRIEF.md
# Gated Edge-Count Frequency Counter

This block measures the rate of an external digital signal by counting its rising edges over a time window of exact, programmable length. The window is produced inside the block by a pulse-width timer that runs on the system clock. Each timer period opens the window at its start and closes it when the timer reaches the programmed gate length. The rest of the period is a guard interval. During the guard interval the finished count is latched and the edge counter is cleared, so the next window starts from zero.

The external signal passes through a two-flop synchronizer and a rising-edge detector in the system clock domain. Any signal whose high and low phases each last at least one system clock is counted exactly, which puts the measurable rate at up to half the system clock. Each result comes with a one-cycle valid strobe. Converting the count to hertz is left to the consumer, which divides by the known gate length.

The gate length and period inputs are sampled only when a new timer period begins. A change made in the middle of a period therefore never shortens or stretches the window that is running.

Top module: `freq_gate_counter`

## Requirements
- R1: While reset is asserted and until the first window closes, `count_out` is 0 and `count_valid` is 0.
- R2: Each rising edge of `sig_in` whose high and low phases each last at least one clock is counted exactly once, including a pattern of one clock high and one clock low (half the clock rate).
- R3: The gate is open for the first G clocks of each P-clock timer period, where G is the gate length and P the period. Edges that reach the counter while the gate is closed (the guard interval) are not counted.
- R4: On the clock after the gate closes, `count_out` takes the number of edges counted in that window and `count_valid` is high for exactly one clock. `count_out` holds that value until the next window closes.
- R5: The edge counter is cleared on the clock after the valid strobe, so a window with no edges reports 0 even after a window with many edges.
- R6: The count saturates at 2^CNT_W-1 and never wraps within a window.
- R7: `gate_len` and `period_len` are sampled only at the start of a timer period. A change during a period first affects the following period, so the spacing between valid strobes changes from P_old to P_old-G_old+G_new and then to P_new.
- R8: The effective period is at least G+2 clocks, and the effective gate is limited to 2^TMR_W-3. For example, G=50 with P=10 gives valid strobes every 52 clocks.
- R9: A gate length of 0 opens no window, and `count_valid` stays low for as long as it is programmed.
- R10: With a steady configuration, consecutive valid strobes are exactly P clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Signal under test, asynchronous to clk |
| gate_len | input | TMR_W | Window length G, in clocks |
| period_len | input | TMR_W | Timer period P, in clocks |
| count_out | output | CNT_W | Edge count of the last completed window |
| count_valid | output | 1 | One-clock strobe marking a new count |

## Verification
A rise driven on `sig_in` in clock c reaches the counter in clock c+2, after two synchronizer flops. The bench therefore starts driving edges only after the window has been open for a clock, and finishes at least eight clocks before it closes. Guard-interval edges are driven so that they land more than twenty clocks before the window opens. The result and strobe appear one clock after the gate falls. The bench waits for the strobe at the falling clock edge and reads the count in that same cycle. Spacing checks compare the cycle numbers of successive strobes against the period arithmetic stated in R7, R8 and R10.

// File: rtl/fc_pkg.sv
package fc_pkg;

    // Default number of synchronizer flops in front of the edge detector.
    localparam int FC_SYNC_DEFAULT = 2;

    // Phase of the window generator's output.
    typedef enum logic {
        GATE_CLOSED = 1'b0,
        GATE_OPEN   = 1'b1
    } gate_st_e;

endpackage

// File: rtl/fc_edge_sync.sv
module fc_edge_sync #(
    parameter int STAGES = fc_pkg::FC_SYNC_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise_o
);

    // chain[0..STAGES-1]: synchronizer flops; chain[STAGES]: history for the edge detector
    typedef struct packed {
        logic [STAGES:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-1:0], sig_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise_o = s_q.chain[STAGES-1] & ~s_q.chain[STAGES];

endmodule

// File: rtl/fc_gate_timer.sv
module fc_gate_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] gate_len_i,
    input  logic [TMR_W-1:0] period_len_i,
    output logic             gate_o
);
    import fc_pkg::*;

    localparam logic [TMR_W-1:0] TMAX     = {TMR_W{1'b1}};
    localparam logic [TMR_W-1:0] GATE_LIM = TMAX - TMR_W'(2);

    typedef struct packed {
        logic [TMR_W-1:0] tmr;     // position inside the current period
        logic [TMR_W-1:0] gate_sh; // gate length in force this period
        logic [TMR_W-1:0] per_sh;  // period length in force this period
        gate_st_e         st;
        logic             start;   // first period after reset not yet loaded
    } tmr_t;

    tmr_t t_d, t_q;

    logic [TMR_W-1:0] g_eff;
    logic [TMR_W-1:0] p_min;
    logic [TMR_W-1:0] p_eff;
    logic [TMR_W-1:0] tmr_inc;
    logic             wrap;

    // Clamp the requested lengths so that the guard interval is at least two clocks.
    always_comb begin
        g_eff = (gate_len_i > GATE_LIM) ? GATE_LIM : gate_len_i;
        p_min = g_eff + TMR_W'(2);
        p_eff = (period_len_i < p_min) ? p_min : period_len_i;
    end

    always_comb begin
        tmr_inc = t_q.tmr + TMR_W'(1);
        wrap    = t_q.start || (t_q.tmr == (t_q.per_sh - TMR_W'(1)));

        t_d       = t_q;
        t_d.start = 1'b0;
        if (wrap) begin
            t_d.tmr     = '0;
            t_d.gate_sh = g_eff;
            t_d.per_sh  = p_eff;
            t_d.st      = (g_eff != '0) ? GATE_OPEN : GATE_CLOSED;
        end else begin
            t_d.tmr = tmr_inc;
            t_d.st  = (tmr_inc < t_q.gate_sh) ? GATE_OPEN : GATE_CLOSED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.tmr     <= '0;
            t_q.gate_sh <= '0;
            t_q.per_sh  <= TMR_W'(2);
            t_q.st      <= GATE_CLOSED;
            t_q.start   <= 1'b1;
        end else begin
            t_q <= t_d;
        end
    end

    assign gate_o = (t_q.st == GATE_OPEN);

endmodule

// File: rtl/fc_edge_count.sv
module fc_edge_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_i,
    input  logic             rise_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] result_o,
    output logic             valid_o
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] result;
        logic             valid;
        logic             gate_dly;
    } cnt_t;

    cnt_t c_d, c_q;
    logic fall;

    always_comb begin
        fall = c_q.gate_dly & ~gate_i;

        c_d          = c_q;
        c_d.gate_dly = gate_i;
        c_d.valid    = 1'b0;

        // Latch the finished window on the gate's falling edge.
        if (fall) begin
            c_d.result = c_q.cnt;
            c_d.valid  = 1'b1;
        end

        // Clear the counter one clock after the result is latched, otherwise count with saturation.
        if (c_q.valid) begin
            c_d.cnt = '0;
        end else if (gate_i && rise_i && (c_q.cnt != CMAX)) begin
            c_d.cnt = c_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt_o    = c_q.cnt;
    assign result_o = c_q.result;
    assign valid_o  = c_q.valid;

endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter #(
    parameter int CNT_W       = 16,
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = fc_pkg::FC_SYNC_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic [TMR_W-1:0] gate_len,
    input  logic [TMR_W-1:0] period_len,
    output logic [CNT_W-1:0] count_out,
    output logic             count_valid
);

    logic             rise_w;
    logic             gate_w;
    logic [CNT_W-1:0] cnt_w;

    fc_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (sig_in),
        .rise_o (rise_w)
    );

    fc_gate_timer #(.TMR_W(TMR_W)) i_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .gate_len_i   (gate_len),
        .period_len_i (period_len),
        .gate_o       (gate_w)
    );

    fc_edge_count #(.CNT_W(CNT_W)) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_i   (gate_w),
        .rise_i   (rise_w),
        .cnt_o    (cnt_w),
        .result_o (count_out),
        .valid_o  (count_valid)
    );

endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate,
    input logic             rise,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] result,
    input logic             valid
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // R4: strobe lasts exactly one clock
    p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R4: gate falling edge delivers the count one clock later
    p_result_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate) |=> (valid && result == $past(cnt)));

    // R4: result holds between strobes
    p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(result));

    // R5: counter is zero the clock after the strobe
    p_clear_after_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> (cnt == '0));

    // R3: an edge inside the window advances the counter by one
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && rise && !valid && cnt != CMAX) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R3: no counting while the gate is closed
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !valid) |=> $stable(cnt));

    // R6: a saturated count stays saturated until cleared
    p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CMAX && !valid) |=> (cnt == CMAX));

    // R8: the guard interval keeps the gate closed while the strobe is up
    p_valid_gate_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !gate);

endmodule

bind freq_gate_counter fc_checker #(.CNT_W(CNT_W)) i_fc_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate   (gate_w),
    .rise   (rise_w),
    .cnt    (cnt_w),
    .result (count_out),
    .valid  (count_valid)
);

// File: tb/test_freq_gate_counter.sv
`timescale 1ns/1ps
module test_freq_gate_counter;

    localparam int CW = 6;
    localparam int TW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sig_in = 1'b0;
    logic [TW-1:0] gate_len;
    logic [TW-1:0] period_len;
    logic [CW-1:0] count_out;
    logic          count_valid;

    int g_cfg = 100;
    int p_cfg = 140;
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    assign gate_len   = TW'(g_cfg);
    assign period_len = TW'(p_cfg);

    always #4 clk = ~clk; // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    freq_gate_counter #(.CNT_W(CW), .TMR_W(TW)) i_freq_gate_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .sig_in      (sig_in),
        .gate_len    (gate_len),
        .period_len  (period_len),
        .count_out   (count_out),
        .count_valid (count_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_valid(output int at);
        int k = 0;
        at = -1;
        do begin
            @(negedge clk);
            k++;
        end while (!count_valid && k < 3000);
        if (count_valid) at = cyc;
        else check("timeout waiting for strobe", 0, 1);
    endtask

    task automatic pulses(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            sig_in = 1'b1;
            repeat (hi) @(negedge clk);
            sig_in = 1'b0;
            repeat (lo) @(negedge clk);
        end
    endtask

    // Waits for a strobe, drives n pulses inside the next window, returns its count.
    task automatic run_window(input int n, input int hi, input int lo, output int res);
        int v;
        wait_valid(v);
        repeat (p_cfg - g_cfg) @(negedge clk);
        pulses(n, hi, lo);
        wait_valid(v);
        res = int'(count_out);
    endtask

    task automatic set_cfg(input int g, input int p);
        int v;
        wait_valid(v);
        g_cfg = g;
        p_cfg = p;
        wait_valid(v);
    endtask

    task automatic t_reset;
        check("R1 count after reset", int'(count_out), 0);
        check("R1 valid after reset", int'(count_valid), 0);
    endtask

    task automatic t_basic;
        int r;
        run_window(10, 2, 2, r);
        check("R4 count of 10 edges", r, 10);
        @(negedge clk);
        check("R4 strobe single clock", int'(count_valid), 0);
        repeat (5) @(negedge clk);
        check("R4 result held", int'(count_out), 10);
    endtask

    task automatic t_fast;
        int r;
        run_window(20, 1, 1, r);
        check("R2 half-rate edges", r, 20);
        run_window(7, 3, 5, r);
        check("R2 slow edges", r, 7);
    endtask

    task automatic t_clear;
        int r;
        run_window(0, 2, 2, r);
        check("R5 empty window after busy one", r, 0);
    endtask

    task automatic t_guard;
        int v;
        wait_valid(v);
        pulses(5, 2, 2);                       // lands in the guard interval
        repeat (p_cfg - g_cfg - 20) @(negedge clk);
        pulses(3, 2, 2);
        wait_valid(v);
        check("R3 guard edges ignored", int'(count_out), 3);
    endtask

    task automatic t_spacing;
        int a, b;
        wait_valid(a);
        wait_valid(b);
        check("R10 strobe spacing", b - a, p_cfg);
    endtask

    task automatic t_shadow;
        int v1, v2, v3, v4;
        wait_valid(v1);
        repeat (p_cfg - g_cfg + 5) @(negedge clk);
        g_cfg = 60;
        p_cfg = 90;
        wait_valid(v2);
        check("R7 running period unchanged", v2 - v1, 140);
        wait_valid(v3);
        check("R7 transition spacing", v3 - v2, 140 - 100 + 60);
        wait_valid(v4);
        check("R7 new period", v4 - v3, 90);
    endtask

    task automatic t_clamp;
        int a, b;
        set_cfg(50, 10);
        wait_valid(a);
        wait_valid(b);
        check("R8 period clamped to G+2", b - a, 52);
    endtask

    task automatic t_zero;
        int seen = 0;
        int v;
        wait_valid(v);
        g_cfg = 0;
        p_cfg = 40;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (count_valid) seen++;
        end
        check("R9 no strobe with zero gate", seen, 0);
        g_cfg = 100;
        p_cfg = 140;
        wait_valid(v);
    endtask

    task automatic t_sat;
        int r;
        set_cfg(500, 540);
        run_window(100, 2, 2, r);
        check("R6 count saturates", r, (1 << CW) - 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_fast();
        t_clear();
        t_guard();
        t_spacing();
        t_shadow();
        t_clamp();
        t_zero();
        t_sat();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule